// File: doc/BRIEF.md
# DMA Channel Completion Reporter

This block gathers the end-of-transaction outcomes of a multi-channel descriptor DMA engine and turns them into readable result words and one level interrupt. Each channel engine reports with single-cycle pulses: a completion of its descriptor list, a failure, or an acknowledge that a requested abort has taken effect. The reporter latches the outcome as a result word for that channel and marks a result-present flag. If the channel's configuration allows it, the reporter also raises that channel's bit in an interrupt source bitmap.

Software reaches the block through a simple register port. Addresses are word-indexed. Bits [6:4] select a register group and bits [3:0] select the channel. The groups are: 0 result word (reading it consumes the result), 1 channel status, 2 result configuration, 3 abort request (write only), and 4 interrupt source bitmap (the channel field is ignored). Reads are combinational. A read of the result group takes effect at the clock edge that ends the read cycle. Writes also take effect at that clock edge, except the abort request, which is forwarded to the channel engine during the write cycle itself.

Top module: `dma_rslt_irq`

## Requirements
- R1: After reset every result word, status word, configuration and the source bitmap read zero, and `irq_o` is low.
- R2: A `done_i` pulse on channel i makes its result word read 0x80000002 (bit 31 valid, bit 1 list done) from the next cycle on, and makes status bit 1 read 1.
- R3: An `err_i` pulse posts 0x80000008 (bit 3 error). `done_i` and `err_i` together post 0x8000000A.
- R4: A write to group 3 drives `flush_req_o[i]` high in that same cycle and no other write does so. A `flush_ack_i` pulse posts 0x8000000C (bit 2 flushed plus bit 3 error).
- R5: Reading the result word returns it, and from the next cycle clears the valid bit, status bit 1 and source bit i.
- R6: Source bit i is set while the result is valid and configuration bit 0 (interrupt enable) is 1. For a flushed result, configuration bit 1 (flush-report enable) must also be 1.
- R7: Writing zero to a channel's configuration clears its source bit on the next cycle, and the result stays readable.
- R8: `irq_o` is the OR of all source bits.
- R9: A new outcome overwrites an unread result. An outcome arriving in the same cycle as a result read wins, so the valid bit stays set.
- R10: A flush acknowledge in the same cycle as `done_i` posts the flush result 0x8000000C.
- R11: Channels report independently, and reading group 4 has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| done_i | input | 16 | per-channel list-complete pulse |
| err_i | input | 16 | per-channel failure pulse |
| flush_ack_i | input | 16 | per-channel abort-taken pulse |
| flush_req_o | output | 16 | per-channel abort request to engines |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 7 | write address {group, channel} |
| wr_data | input | 2 | configuration data (bit 0 irq enable, bit 1 flush report) |
| rd_en | input | 1 | register read strobe |
| rd_addr | input | 7 | read address {group, channel} |
| rd_data | output | 32 | read data, combinational |
| irq_o | output | 1 | level interrupt |

## Verification
The bench goes after three collisions: an outcome that lands on an unread result, an outcome that lands in the same cycle as the read that consumes the result, and a flush acknowledge that lands together with a done pulse. A design that gave the read priority would lose a completion and leave the engine stalled. A design that let done beat the flush would report a failed transfer as clean. The bench also checks that an aborted result with flush reporting off stays silent while its word is still readable, and that masking a channel drops the interrupt without erasing the result.

// File: rtl/dma_rslt_pkg.sv
package dma_rslt_pkg;
  localparam int WORD_W  = 32;
  localparam int VLD_BIT = 31;
  localparam int ERR_BIT = 3;
  localparam int FLS_BIT = 2;
  localparam int TPD_BIT = 1;
  localparam int STS_BIT = 1;
  localparam int IEN_BIT = 0;
  localparam int FEN_BIT = 1;
  localparam int CFG_W   = 2;
  localparam int GRP_W   = 3;

  typedef enum logic [GRP_W-1:0] {
    GRP_RSLT  = 3'd0,
    GRP_STAT  = 3'd1,
    GRP_CONF  = 3'd2,
    GRP_FLUSH = 3'd3,
    GRP_SRC   = 3'd4
  } grp_e;

  function automatic logic [WORD_W-1:0] pack_rslt(input logic v, input logic e,
                                                  input logic f, input logic t);
    logic [WORD_W-1:0] w;
    w = '0;
    w[VLD_BIT] = v;
    w[ERR_BIT] = e;
    w[FLS_BIT] = f;
    w[TPD_BIT] = t;
    return w;
  endfunction

  function automatic logic src_pend(input logic v, input logic f,
                                    input logic [CFG_W-1:0] cfg);
    return v & cfg[IEN_BIT] & (~f | cfg[FEN_BIT]);
  endfunction
endpackage

// File: rtl/dma_rslt_chan.sv
module dma_rslt_chan
  import dma_rslt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic              err_i,
  input  logic              fack_i,
  input  logic              rd_clr_i,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_d_i,
  output logic [WORD_W-1:0] rslt_o,
  output logic              valid_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              src_o
);
  logic valid_q, err_q, fls_q, tpd_q;
  logic [CFG_W-1:0] cfg_q;
  logic evt;

  assign evt = done_i | err_i | fack_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      fls_q   <= 1'b0;
      tpd_q   <= 1'b0;
    end else if (evt) begin
      valid_q <= 1'b1;
      if (fack_i) begin
        err_q <= 1'b1;
        fls_q <= 1'b1;
        tpd_q <= 1'b0;
      end else begin
        err_q <= err_i;
        fls_q <= 1'b0;
        tpd_q <= done_i;
      end
    end else if (rd_clr_i) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_d_i;
  end

  assign rslt_o  = pack_rslt(valid_q, err_q, fls_q, tpd_q);
  assign valid_o = valid_q;
  assign cfg_o   = cfg_q;
  assign src_o   = src_pend(valid_q, fls_q, cfg_q);

  p_evt_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> valid_o);
  p_read_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && !evt) |=> !valid_o && !src_o);
  p_flush_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fack_i |=> (rslt_o[ERR_BIT] && rslt_o[FLS_BIT]));
  p_cfg_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && cfg_d_i == '0) |=> !src_o);
endmodule

// File: rtl/dma_rslt_regif.sv
module dma_rslt_regif
  import dma_rslt_pkg::*;
#(
  parameter int NCH = 16,
  localparam int CW = $clog2(NCH),
  localparam int AW = CW + GRP_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [AW-1:0]                 wr_addr,
  input  logic                          rd_en,
  input  logic [AW-1:0]                 rd_addr,
  input  logic [NCH-1:0][WORD_W-1:0]    rslt_i,
  input  logic [NCH-1:0]                valid_i,
  input  logic [NCH-1:0][CFG_W-1:0]     cfg_i,
  input  logic [NCH-1:0]                src_i,
  output logic [NCH-1:0]                rd_clr_o,
  output logic [NCH-1:0]                cfg_we_o,
  output logic [NCH-1:0]                flush_req_o,
  output logic [WORD_W-1:0]             rd_data
);
  grp_e wgrp, rgrp;
  logic [CW-1:0] wch, rch;

  assign wgrp = grp_e'(wr_addr[AW-1 -: GRP_W]);
  assign rgrp = grp_e'(rd_addr[AW-1 -: GRP_W]);
  assign wch  = wr_addr[CW-1:0];
  assign rch  = rd_addr[CW-1:0];

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    assign rd_clr_o[i]    = rd_en && rgrp == GRP_RSLT  && rch == CW'(i);
    assign cfg_we_o[i]    = wr_en && wgrp == GRP_CONF  && wch == CW'(i);
    assign flush_req_o[i] = wr_en && wgrp == GRP_FLUSH && wch == CW'(i);
  end

  always_comb begin
    rd_data = '0;
    case (rgrp)
      GRP_RSLT: rd_data = rslt_i[rch];
      GRP_STAT: rd_data[STS_BIT] = valid_i[rch];
      GRP_CONF: rd_data[CFG_W-1:0] = cfg_i[rch];
      GRP_SRC:  rd_data = WORD_W'(src_i);
      default:  rd_data = '0;
    endcase
  end

  p_one_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flush_req_o));
endmodule

// File: rtl/dma_rslt_irq.sv
module dma_rslt_irq
  import dma_rslt_pkg::*;
#(
  parameter int NCH = 16,
  localparam int CW = $clog2(NCH),
  localparam int AW = CW + GRP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    done_i,
  input  logic [NCH-1:0]    err_i,
  input  logic [NCH-1:0]    flush_ack_i,
  output logic [NCH-1:0]    flush_req_o,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              irq_o
);
  logic [NCH-1:0][WORD_W-1:0] rslt;
  logic [NCH-1:0][CFG_W-1:0]  cfg;
  logic [NCH-1:0] valid, src, rd_clr, cfg_we, evt_any;

  assign evt_any = done_i | err_i | flush_ack_i;

  dma_rslt_regif #(.NCH(NCH)) u_regif (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en), .rd_addr(rd_addr),
    .rslt_i(rslt), .valid_i(valid), .cfg_i(cfg), .src_i(src),
    .rd_clr_o(rd_clr), .cfg_we_o(cfg_we), .flush_req_o(flush_req_o),
    .rd_data(rd_data)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma_rslt_chan u_ch (
      .clk(clk), .rst_n(rst_n),
      .done_i(done_i[i]), .err_i(err_i[i]), .fack_i(flush_ack_i[i]),
      .rd_clr_i(rd_clr[i]), .cfg_we_i(cfg_we[i]), .cfg_d_i(wr_data),
      .rslt_o(rslt[i]), .valid_o(valid[i]), .cfg_o(cfg[i]), .src_o(src[i])
    );
  end

  assign irq_o = |src;

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past((|evt_any) || (|cfg_we)));
  p_irq_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past((|rd_clr) || (|cfg_we)));
endmodule

// File: tb/dma_rslt_irq_test.sv
module dma_rslt_irq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] done_i = '0, err_i = '0, flush_ack_i = '0, flush_req_o;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [6:0] wr_addr = '0, rd_addr = '0;
  logic [1:0] wr_data = '0;
  logic [31:0] rd_data;
  logic irq_o;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_rslt_irq uut (.*);

  // fields: [40:37] channel, [36:35] kind (0 done,1 err,2 both,3 flush),
  // [34:33] config, [32:1] expected word, [0] expected source bit
  localparam logic [40:0] VEC [7] = '{
    {4'd3,  2'd0, 2'b01, 32'h8000_0002, 1'b1},
    {4'd7,  2'd1, 2'b01, 32'h8000_0008, 1'b1},
    {4'd0,  2'd2, 2'b01, 32'h8000_000A, 1'b1},
    {4'd15, 2'd3, 2'b11, 32'h8000_000C, 1'b1},
    {4'd9,  2'd3, 2'b01, 32'h8000_000C, 1'b0},
    {4'd5,  2'd0, 2'b00, 32'h8000_0002, 1'b0},
    {4'd12, 2'd0, 2'b10, 32'h8000_0002, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int grp, input int ch, input logic [1:0] d);
    wr_en = 1'b1; wr_addr = {3'(grp), 4'(ch)}; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int grp, input int ch, output logic [31:0] v);
    rd_en = 1'b1; rd_addr = {3'(grp), 4'(ch)};
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] d, input logic [15:0] e, input logic [15:0] f);
    done_i = d; err_i = e; flush_ack_i = f;
    @(negedge clk);
    done_i = '0; err_i = '0; flush_ack_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 32'(irq_o), 0);
    rd(4, 0, v);  chk("R1 src", v, 0);
    rd(0, 3, v);  chk("R1 result", v, 0);
    rd(2, 3, v);  chk("R1 config", v, 0);

    foreach (VEC[k]) begin
      automatic int ch = int'(VEC[k][40:37]);
      automatic logic [1:0] kind = VEC[k][36:35];
      automatic logic [15:0] b = 16'(1) << ch;
      wr(2, ch, VEC[k][34:33]);
      chk("R4 no flush on config write", 32'(flush_req_o), 0);
      if (kind == 2'd3) begin
        wr_en = 1'b1; wr_addr = {3'd3, 4'(ch)}; wr_data = '0;
        #1 chk("R4 flush request", 32'(flush_req_o), 32'(b));
        @(negedge clk); wr_en = 1'b0;
        pulse('0, '0, b);
      end else begin
        pulse(kind[1] || kind == 2'd0 ? b : '0, kind != 2'd0 ? b : '0, '0);
      end
      rd(4, 0, v);  chk("R6 source bit", 32'(v[ch]), 32'(VEC[k][0]));
      chk("R8 irq follows source", 32'(irq_o), 32'(VEC[k][0]));
      rd(1, ch, v); chk("R2 status set", v, 32'h2);
      rd(0, ch, v); chk("R2 R3 R4 result word", v, VEC[k][32:1]);
      rd(1, ch, v); chk("R5 status cleared", v, 0);
      rd(0, ch, v); chk("R5 valid cleared", 32'(v[31]), 0);
      chk("R5 irq cleared", 32'(irq_o), 0);
      wr(2, ch, 2'b00);
    end

    // R9 overwrite of an unread result, then outcome vs read in one cycle
    wr(2, 2, 2'b01);
    pulse(16'h0004, '0, '0);
    pulse('0, 16'h0004, '0);
    rd_en = 1'b1; rd_addr = {3'd0, 4'd2}; done_i = 16'h0004;
    #1 chk("R9 overwrite", rd_data, 32'h8000_0008);
    @(negedge clk); rd_en = 1'b0; done_i = '0;
    rd(0, 2, v); chk("R9 event beats read", v, 32'h8000_0002);
    wr(2, 2, 2'b00);

    // R10 flush ack together with done
    pulse(16'h0010, '0, 16'h0010);
    rd(0, 4, v); chk("R10 flush wins", v, 32'h8000_000C);

    // R7 masking keeps result
    wr(2, 6, 2'b01);
    pulse(16'h0040, '0, '0);
    chk("R7 irq before mask", 32'(irq_o), 1);
    wr(2, 6, 2'b00);
    chk("R7 irq after mask", 32'(irq_o), 0);
    rd(0, 6, v); chk("R7 result kept", v, 32'h8000_0002);

    // R11 independent channels, source read has no side effect
    wr(2, 1, 2'b01);
    wr(2, 8, 2'b01);
    pulse(16'h0102, '0, '0);
    rd(4, 0, v); chk("R11 both pending", v, 32'h0102);
    rd(4, 0, v); chk("R11 source read no effect", v, 32'h0102);
    rd(0, 1, v); chk("R11 ch1 result", v, 32'h8000_0002);
    rd(4, 0, v); chk("R11 ch8 still pending", v, 32'h0100);
    chk("R8 irq with one left", 32'(irq_o), 1);
    rd(0, 8, v);
    chk("R8 irq all read", 32'(irq_o), 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule